// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block decides which clocks and oscillators of a small microcontroller run at any moment. It watches a copy of four mode bits from the processor status word (CPU off, oscillator off, and the two system-clock-gate bits). It also watches per-peripheral requests for the main, sub-main and auxiliary clocks, the source choice of each of those three clocks, a pending-interrupt line and a return-from-interrupt strobe. From these it produces registered enables for the CPU, the three clocks and the two oscillators. The clock gate cells themselves sit outside.

The processor writes a low-power mode into the status bits. The controller samples them only on cycles when the CPU is running and no interrupt is being serviced. The resulting sleep mode is held until an interrupt arrives. The interrupt forces active mode for the length of the service routine. The return strobe then restores the mode that was saved. A peripheral that still needs a clock keeps that clock on in any mode, but this never releases the CPU. The high-frequency oscillator runs only while at least one enabled clock takes it as its source.

Top module: `lpm_clkgate_ctrl`

## Requirements
- R1: While reset is asserted, and until the first update after it, all six enables (CPU, MCLK, SMCLK, ACLK, HF oscillator, LF oscillator) are 1 and the controller is in active mode.
- R2: The status bits are decoded as follows. CPU-off = 0 gives active mode. CPU-off = 1 with osc-off = 1 gives the deepest mode (LPM4), whatever the clock-gate bits are. CPU-off = 1, osc-off = 0 and gate-1 = 1 gives LPM3, so the LPM2 code acts as LPM3. CPU-off = 1, osc-off = 0 and gate-1 = 0 gives LPM0, so the LPM1 code acts as LPM0. Gate-0 never has an effect.
- R3: With no peripheral requests, the mode alone sets the enables. Active mode turns on the CPU, MCLK, SMCLK and ACLK. LPM0 turns on SMCLK and ACLK only. LPM3 turns on ACLK only. LPM4 turns on none of the four.
- R4: A select input of 1 means that clock takes the HF oscillator. The HF oscillator enable is 1 exactly when at least one of MCLK, SMCLK or ACLK is enabled and selects it.
- R5: A request from any peripheral source for MCLK, SMCLK or ACLK forces that clock's enable to 1 in every mode. The CPU enable stays 0 while the block is asleep.
- R6: The status bits are ignored while the block is asleep and while an interrupt is being serviced. Changing them in those states leaves the enables unchanged.
- R7: When an interrupt is pending and none is being serviced, the controller enters service, which behaves as active mode (CPU, MCLK, SMCLK and ACLK on).
- R8: A return strobe during service ends it and restores the mode that was in force when the interrupt arrived.
- R9: The LF oscillator enable is 1 in every mode.
- R10: Every enable is a register output. A change in the status bits, the interrupt line or the return strobe reaches the enables at the second rising clock edge. A change in a peripheral request or a source select reaches them at the first rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sr_cpu_off | input | 1 | Status image: CPU-off bit |
| sr_osc_off | input | 1 | Status image: oscillator-off bit |
| sr_scg0 | input | 1 | Status image: clock-gate bit 0 (no effect) |
| sr_scg1 | input | 1 | Status image: clock-gate bit 1 |
| irq_pend | input | 1 | An enabled interrupt is pending |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| mclk_req | input | N_REQ | Per-peripheral MCLK requests |
| smclk_req | input | N_REQ | Per-peripheral SMCLK requests |
| aclk_req | input | N_REQ | Per-peripheral ACLK requests |
| mclk_src_hf | input | 1 | MCLK takes the HF oscillator when 1 |
| smclk_src_hf | input | 1 | SMCLK takes the HF oscillator when 1 |
| aclk_src_hf | input | 1 | ACLK takes the HF oscillator when 1 |
| cpu_en | output | 1 | CPU run enable |
| mclk_en | output | 1 | MCLK gate enable |
| smclk_en | output | 1 | SMCLK gate enable |
| aclk_en | output | 1 | ACLK gate enable |
| hfosc_en | output | 1 | HF oscillator power enable |
| lfosc_en | output | 1 | LF oscillator power enable |

## Verification
Status-bit, interrupt and return stimuli are applied at a falling edge. They are checked at the falling edge that follows the second rising edge: one register holds the mode state and one holds the enables. Peripheral requests and source selects pass through the enable register only, so they are checked one rising edge after they are applied. The bench sweeps all sixteen status codes against all eight source-select patterns and all seven request patterns. Every sample is taken at mid-cycle, so each expected enable vector is compared only once its due edge has passed.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_ACT = 2'd0,
    MODE_L0  = 2'd1,
    MODE_L3  = 2'd2,
    MODE_L4  = 2'd3
  } lpm_mode_e;

  typedef struct packed {
    logic cpu;
    logic mclk;
    logic smclk;
    logic aclk;
    logic hfosc;
    logic lfosc;
  } clk_en_t;

  localparam int N_CLK = 3;
  localparam int CLK_M = 0;
  localparam int CLK_S = 1;
  localparam int CLK_A = 2;

endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/lpm_mode_decode.sv
module lpm_mode_decode
  import lpm_pkg::*;
(
  input  logic      cpu_off,
  input  logic      osc_off,
  input  logic      scg0,
  input  logic      scg1,
  output lpm_mode_e mode
);

  // Gate-0 only steers an oscillator control that has no effect here.
  logic scg0_unused;
  assign scg0_unused = scg0;

  always_comb begin
    if (!cpu_off)     mode = MODE_ACT;
    else if (osc_off) mode = MODE_L4;
    else if (scg1)    mode = MODE_L3;
    else              mode = MODE_L0;
  end

endmodule

// File: rtl/lpm_wake_fsm.sv
module lpm_wake_fsm
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lpm_mode_e req_mode,
  input  logic      irq_pend,
  input  logic      irq_ret,
  output lpm_mode_e sleep_mode,
  output logic      in_isr,
  output lpm_mode_e eff_mode
);

  lpm_mode_e sleep_q, sleep_d;
  logic      isr_q, isr_d;
  logic      sleep_ld, isr_ld;

  // Next-state logic: status bits load only while running outside service.
  always_comb begin
    sleep_d  = sleep_q;
    isr_d    = isr_q;
    sleep_ld = 1'b0;
    isr_ld   = 1'b0;
    if (isr_q) begin
      if (irq_ret) begin
        isr_d  = 1'b0;
        isr_ld = 1'b1;
      end
    end else if (irq_pend) begin
      isr_d  = 1'b1;
      isr_ld = 1'b1;
    end else if (sleep_q == MODE_ACT) begin
      sleep_d  = req_mode;
      sleep_ld = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= MODE_ACT;
      isr_q   <= 1'b0;
    end else begin
      if (sleep_ld) sleep_q <= sleep_d;
      if (isr_ld)   isr_q   <= isr_d;
    end
  end

  assign sleep_mode = sleep_q;
  assign in_isr     = isr_q;
  assign eff_mode   = isr_q ? MODE_ACT : sleep_q;

endmodule

// File: rtl/lpm_enable_reg.sv
module lpm_enable_reg
  import lpm_pkg::*;
#(
  parameter int N_REQ = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  lpm_mode_e                   eff_mode,
  input  logic [N_CLK-1:0][N_REQ-1:0] req,
  input  logic [N_CLK-1:0]            src_hf,
  output clk_en_t                     en
);

  logic [N_CLK-1:0] mode_on;
  logic [N_CLK-1:0] clk_d;
  logic [N_CLK-1:0] hf_use;
  clk_en_t          en_d, en_q;

  always_comb begin
    mode_on[CLK_M] = (eff_mode == MODE_ACT);
    mode_on[CLK_S] = (eff_mode == MODE_ACT) || (eff_mode == MODE_L0);
    mode_on[CLK_A] = (eff_mode != MODE_L4);
  end

  for (genvar g = 0; g < N_CLK; g++) begin : g_clk
    assign clk_d[g]  = mode_on[g] | (|req[g]);
    assign hf_use[g] = clk_d[g] & src_hf[g];
  end

  always_comb begin
    en_d.cpu   = (eff_mode == MODE_ACT);
    en_d.mclk  = clk_d[CLK_M];
    en_d.smclk = clk_d[CLK_S];
    en_d.aclk  = clk_d[CLK_A];
    en_d.hfosc = |hf_use;
    en_d.lfosc = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '1;
    else        en_q <= en_d;
  end

  assign en = en_q;

endmodule

// File: rtl/lpm_clkgate_ctrl.sv
module lpm_clkgate_ctrl
  import lpm_pkg::*;
#(
  parameter int N_REQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sr_cpu_off,
  input  logic             sr_osc_off,
  input  logic             sr_scg0,
  input  logic             sr_scg1,
  input  logic             irq_pend,
  input  logic             irq_ret,
  input  logic [N_REQ-1:0] mclk_req,
  input  logic [N_REQ-1:0] smclk_req,
  input  logic [N_REQ-1:0] aclk_req,
  input  logic             mclk_src_hf,
  input  logic             smclk_src_hf,
  input  logic             aclk_src_hf,
  output logic             cpu_en,
  output logic             mclk_en,
  output logic             smclk_en,
  output logic             aclk_en,
  output logic             hfosc_en,
  output logic             lfosc_en
);

  logic                        rst_sync_n;
  lpm_mode_e                   req_mode;
  lpm_mode_e                   sleep_mode;
  lpm_mode_e                   eff_mode;
  logic                        in_isr;
  logic [N_CLK-1:0][N_REQ-1:0] req_arr;
  logic [N_CLK-1:0]            src_arr;
  clk_en_t                     en;

  assign req_arr = {aclk_req, smclk_req, mclk_req};
  assign src_arr = {aclk_src_hf, smclk_src_hf, mclk_src_hf};

  lpm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lpm_mode_decode u_dec (
    .cpu_off (sr_cpu_off),
    .osc_off (sr_osc_off),
    .scg0    (sr_scg0),
    .scg1    (sr_scg1),
    .mode    (req_mode)
  );

  lpm_wake_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req_mode   (req_mode),
    .irq_pend   (irq_pend),
    .irq_ret    (irq_ret),
    .sleep_mode (sleep_mode),
    .in_isr     (in_isr),
    .eff_mode   (eff_mode)
  );

  lpm_enable_reg #(.N_REQ(N_REQ)) u_en (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .eff_mode (eff_mode),
    .req      (req_arr),
    .src_hf   (src_arr),
    .en       (en)
  );

  assign cpu_en   = en.cpu;
  assign mclk_en  = en.mclk;
  assign smclk_en = en.smclk;
  assign aclk_en  = en.aclk;
  assign hfosc_en = en.hfosc;
  assign lfosc_en = en.lfosc;

endmodule

// File: rtl/lpm_clkgate_ctrl_chk.sv
module lpm_clkgate_ctrl_chk
  import lpm_pkg::*;
#(
  parameter int N_REQ = 4
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             irq_pend,
  input logic             irq_ret,
  input logic [N_REQ-1:0] mclk_req,
  input logic [N_REQ-1:0] smclk_req,
  input logic [N_REQ-1:0] aclk_req,
  input logic             cpu_en,
  input logic             mclk_en,
  input logic             smclk_en,
  input logic             aclk_en,
  input logic             lfosc_en,
  input logic             in_isr,
  input lpm_mode_e        sleep_mode
);

  assert_sleep_cpu_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!in_isr && sleep_mode != MODE_ACT) |=> !cpu_en);

  assert_mreq_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|mclk_req) |=> mclk_en);

  assert_sreq_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|smclk_req) |=> smclk_en);

  assert_areq_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|aclk_req) |=> aclk_en);

  assert_ignore_sr_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!in_isr && !irq_pend && sleep_mode != MODE_ACT) |=> $stable(sleep_mode));

  assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!in_isr && irq_pend) |=> in_isr);

  assert_isr_active_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_isr |=> (cpu_en && mclk_en && smclk_en && aclk_en));

  assert_return_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_isr && irq_ret) |=> (!in_isr && $stable(sleep_mode)));

  assert_lf_on_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    lfosc_en);

endmodule

bind lpm_clkgate_ctrl lpm_clkgate_ctrl_chk #(.N_REQ(N_REQ)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .irq_pend   (irq_pend),
  .irq_ret    (irq_ret),
  .mclk_req   (mclk_req),
  .smclk_req  (smclk_req),
  .aclk_req   (aclk_req),
  .cpu_en     (cpu_en),
  .mclk_en    (mclk_en),
  .smclk_en   (smclk_en),
  .aclk_en    (aclk_en),
  .lfosc_en   (lfosc_en),
  .in_isr     (in_isr),
  .sleep_mode (sleep_mode)
);

// File: tb/lpm_clkgate_ctrl_tb.sv
`timescale 1ns/1ps
module lpm_clkgate_ctrl_tb;

  localparam int N_REQ = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             sr_cpu_off, sr_osc_off, sr_scg0, sr_scg1;
  logic             irq_pend, irq_ret;
  logic [N_REQ-1:0] mclk_req, smclk_req, aclk_req;
  logic             mclk_src_hf, smclk_src_hf, aclk_src_hf;
  logic             cpu_en, mclk_en, smclk_en, aclk_en, hfosc_en, lfosc_en;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;

  lpm_clkgate_ctrl #(.N_REQ(N_REQ)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .sr_cpu_off(sr_cpu_off), .sr_osc_off(sr_osc_off),
    .sr_scg0(sr_scg0), .sr_scg1(sr_scg1),
    .irq_pend(irq_pend), .irq_ret(irq_ret),
    .mclk_req(mclk_req), .smclk_req(smclk_req), .aclk_req(aclk_req),
    .mclk_src_hf(mclk_src_hf), .smclk_src_hf(smclk_src_hf), .aclk_src_hf(aclk_src_hf),
    .cpu_en(cpu_en), .mclk_en(mclk_en), .smclk_en(smclk_en),
    .aclk_en(aclk_en), .hfosc_en(hfosc_en), .lfosc_en(lfosc_en)
  );

  // Code bits: {cpu_off, osc_off, scg1, scg0}. Result 0=active 1=LPM0 2=LPM3 3=LPM4.
  function automatic int exp_mode(logic [3:0] c);
    if (!c[3])     return 0;
    else if (c[2]) return 3;
    else if (c[1]) return 2;
    else           return 1;
  endfunction

  // req and sel bits: {mclk, smclk, aclk}. Result {cpu,mclk,smclk,aclk,hf,lf}.
  function automatic logic [5:0] exp_en(int mode, logic [2:0] req, logic [2:0] sel);
    logic c, m, s, a, h;
    c = (mode == 0);
    m = c | req[2];
    s = (mode <= 1) | req[1];
    a = (mode != 3) | req[0];
    h = (m & sel[2]) | (s & sel[1]) | (a & sel[0]);
    return {c, m, s, a, h, 1'b1};
  endfunction

  task automatic check(string tag, logic [5:0] exp);
    logic [5:0] got;
    got = {cpu_en, mclk_en, smclk_en, aclk_en, hfosc_en, lfosc_en};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic set_sr(logic [3:0] c);
    {sr_cpu_off, sr_osc_off, sr_scg1, sr_scg0} = c;
  endtask

  task automatic wait_edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    set_sr(4'h0);
    irq_pend = 1'b0; irq_ret = 1'b0;
    mclk_req = '0; smclk_req = '0; aclk_req = '0;
    {mclk_src_hf, smclk_src_hf, aclk_src_hf} = 3'b000;

    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 8; s++) begin
        int m;
        m = exp_mode(4'(c));
        @(negedge clk);
        rst_n = 1'b0;
        set_sr(4'h0);
        irq_pend = 1'b0; irq_ret = 1'b0;
        mclk_req = '0; smclk_req = '0; aclk_req = '0;
        {mclk_src_hf, smclk_src_hf, aclk_src_hf} = 3'(s);
        wait_edges(2);
        check("R1 R9 reset", 6'b111111);
        rst_n = 1'b1;
        wait_edges(4);
        check("R4 active after reset", exp_en(0, 3'b000, 3'(s)));

        // Mode entry from status bits: due at second rising edge.
        set_sr(4'(c));
        wait_edges(2);
        check("R2 R3 R4 R10 mode entry", exp_en(m, 3'b000, 3'(s)));

        // Status bits changed while asleep must be ignored.
        set_sr(4'h0);
        wait_edges(3);
        check("R6 sleep ignores status", exp_en(m, 3'b000, 3'(s)));

        // Peripheral requests: due at first rising edge.
        for (int r = 1; r < 8; r++) begin
          int idx;
          idx = r % N_REQ;
          mclk_req  = r[2] ? (N_REQ'(1) << idx) : '0;
          smclk_req = r[1] ? (N_REQ'(1) << idx) : '0;
          aclk_req  = r[0] ? (N_REQ'(1) << idx) : '0;
          wait_edges(1);
          check("R5 R4 R10 peripheral request", exp_en(m, 3'(r), 3'(s)));
        end
        mclk_req = '0; smclk_req = '0; aclk_req = '0;
        wait_edges(1);
        check("R5 request release", exp_en(m, 3'b000, 3'(s)));

        // Interrupt wake: due at second rising edge.
        irq_pend = 1'b1;
        set_sr(4'hF);
        @(posedge clk); @(negedge clk);
        irq_pend = 1'b0;
        wait_edges(1);
        check("R7 interrupt wake", exp_en(0, 3'b000, 3'(s)));
        wait_edges(2);
        check("R6 R7 service ignores status", exp_en(0, 3'b000, 3'(s)));

        // Return restores the saved mode.
        irq_ret = 1'b1;
        set_sr(4'h0);
        @(posedge clk); @(negedge clk);
        irq_ret = 1'b0;
        wait_edges(1);
        check("R8 return restores mode", exp_en(m, 3'b000, 3'(s)));
      end
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule